// File: doc/BRIEF.md
# Micro-op Dispatch Throttle

This block sits between instruction decode and the scheduler of an out-of-order core. Each clock it is offered up to `LANES` instructions in program order. Each instruction carries its micro-op count and its number of destination registers. The block decides how many of them leave this cycle. An instruction leaves only when three things all hold: the reorder buffer has room for its micro-ops, the rename pool has enough free physical registers for its destinations, and the scheduler buffer has an entry for it. The reorder buffer, the rename tables and the scheduler are not part of this block. They appear only as free-count inputs and as allocation outputs.

A per-cycle micro-op budget of `WIDTH` limits how much can leave in one clock. When the budget is untouched, an instruction larger than the whole budget is still admitted. Its excess micro-ops are carried into the following cycles, and no new instruction is accepted until that excess is drained. When an eligible instruction is held back for lack of a resource, the block counts the event in a saturating counter for that resource.

Top module: `uop_dispatch`

## Requirements
- R1: A lane dispatches only if, counting the micro-ops, destinations and entries of every lower lane dispatched in the same cycle, the micro-op sum is at most `rob_free_i`, the destination sum is at most `prf_free_i`, and the entry count is at most `sched_free_i`.
- R2: Lane i (fields at `in_uops_i[i*UOP_W +: UOP_W]` and `in_dsts_i[i*DST_W +: DST_W]`) is considered only if every lower lane dispatches in that cycle. A lane above lane 0 fits only while the running micro-op sum stays at most `WIDTH`. An invalid lane stops all higher lanes.
- R3: With no carried micro-ops, lane 0 always fits the budget, even when its count exceeds `WIDTH`.
- R4: An instruction with `u` > `WIDTH` micro-ops leaves `u - WIDTH` micro-ops of carry. Each later cycle drains up to `WIDTH` of the carry. `in_ready_o` stays all-zero while any carry remains.
- R5: `in_ready_o[i]` is the dispatch of lane i in that same cycle. It is never high without `in_valid_i[i]`.
- R6: In a dispatch cycle, `alloc_o` is high, `rob_alloc_o` is the sum of the dispatched micro-op counts, `prf_alloc_o` is the sum of their destination counts, and `sched_alloc_o` is the number of dispatched lanes. In any other cycle all four are zero.
- R7: A cycle adds one to at most one stall counter. A counter is incremented only for the first eligible lane that is blocked by a resource, and the checks for that lane run in the order reorder buffer, register pool, scheduler. Budget limits and carry cycles count nothing.
- R8: Stall counters are `CNT_W` bits wide and hold at all-ones instead of wrapping.
- R9: Reset (`rst_ni` low, asynchronous) clears the carry and all counters, so the first cycle after reset has the full budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | LANES | Per-lane instruction valid |
| in_uops_i | input | LANES*UOP_W | Per-lane micro-op count |
| in_dsts_i | input | LANES*DST_W | Per-lane destination register count |
| in_ready_o | output | LANES | Per-lane dispatch/consume this cycle |
| rob_free_i | input | FREE_W | Free reorder-buffer entries |
| prf_free_i | input | FREE_W | Free physical registers |
| sched_free_i | input | FREE_W | Free scheduler buffer entries |
| alloc_o | output | 1 | Allocation pulse |
| rob_alloc_o | output | SU_W | Reorder-buffer entries taken |
| prf_alloc_o | output | SD_W | Physical registers taken |
| sched_alloc_o | output | LC_W | Scheduler entries taken |
| stall_rob_o | output | CNT_W | Reorder-buffer stall count |
| stall_prf_o | output | CNT_W | Register-pool stall count |
| stall_sched_o | output | CNT_W | Scheduler stall count |

## Verification
The hardest situation to reach from the ports is a carry-drain cycle that coincides with resource shortage. In such a cycle every check would fail, yet nothing may be counted. The stimulus dispatches an oversized instruction and then starves all three free counts while the carry drains, and the scoreboard expects the counters to stay flat until the first cycle that accepts again. Counter saturation is reached by building the bench with narrow counters and holding the reorder buffer full for more cycles than the counter can hold. Resetting in the middle of a carry shows that the next instruction is accepted immediately.

// File: rtl/uop_dispatch_pkg.sv
package uop_dispatch_pkg;
  timeunit 1ns; timeprecision 100ps;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_ROB   = 2'd1,
    CAUSE_PRF   = 2'd2,
    CAUSE_SCHED = 2'd3
  } stall_cause_e;

  localparam int unsigned NUM_CAUSES = 3;
endpackage

// File: rtl/uop_disp_budget.sv
module uop_disp_budget #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned UOP_W = 4,
  localparam int unsigned BUD_W = $clog2(WIDTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [UOP_W-1:0] uops0_i,
  output logic             busy_o,
  output logic [BUD_W-1:0] rem_o
);
  timeunit 1ns; timeprecision 100ps;

  localparam logic [UOP_W-1:0] W_U = UOP_W'(WIDTH);
  localparam logic [BUD_W-1:0] W_B = BUD_W'(WIDTH);

  logic [UOP_W-1:0] carry_q, carry_d;

  // carry drains by WIDTH per cycle; new carry only from an oversized lane 0
  always_comb begin
    carry_d = '0;
    if (carry_q != '0) begin
      if (carry_q > W_U) carry_d = carry_q - W_U;
    end else if (take_i && (uops0_i > W_U)) begin
      carry_d = uops0_i - W_U;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) carry_q <= '0;
    else         carry_q <= carry_d;
  end

  assign busy_o = (carry_q != '0);
  assign rem_o  = (carry_q >= W_U) ? '0 : (W_B - BUD_W'(carry_q));
endmodule

// File: rtl/uop_disp_lanes.sv
module uop_disp_lanes import uop_dispatch_pkg::*; #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned UOP_W  = 4,
  parameter int unsigned DST_W  = 2,
  parameter int unsigned FREE_W = 8,
  localparam int unsigned BUD_W = $clog2(WIDTH + 1),
  localparam int unsigned SU_W  = UOP_W + $clog2(LANES + 1),
  localparam int unsigned SD_W  = DST_W + $clog2(LANES + 1),
  localparam int unsigned LC_W  = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0]       valid_i,
  input  logic [LANES*UOP_W-1:0] uops_i,
  input  logic [LANES*DST_W-1:0] dsts_i,
  input  logic                   busy_i,
  input  logic [BUD_W-1:0]       rem_i,
  input  logic [FREE_W-1:0]      rob_free_i,
  input  logic [FREE_W-1:0]      prf_free_i,
  input  logic [FREE_W-1:0]      sched_free_i,
  output logic [LANES-1:0]       go_o,
  output logic [SU_W-1:0]        rob_sum_o,
  output logic [SD_W-1:0]        prf_sum_o,
  output logic [LC_W-1:0]        sch_cnt_o,
  output stall_cause_e           cause_o
);
  timeunit 1ns; timeprecision 100ps;

  localparam logic [BUD_W-1:0] W_B = BUD_W'(WIDTH);

  logic [SU_W-1:0]  cu [LANES];
  logic [SD_W-1:0]  cd [LANES];
  logic [LANES-1:0] go, blk_rob, blk_prf, blk_sch;
  logic [SU_W-1:0]  rem_s;

  assign rem_s = SU_W'(rem_i);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [UOP_W-1:0] u;
    logic [DST_W-1:0] d;
    logic prior, fit, elig, rob_ok, prf_ok, sch_ok;

    assign u = uops_i[i*UOP_W +: UOP_W];
    assign d = dsts_i[i*DST_W +: DST_W];

    if (i == 0) begin : g_head
      assign cu[i]  = SU_W'(u);
      assign cd[i]  = SD_W'(d);
      assign prior  = ~busy_i;
      // untouched budget admits an oversized head
      assign fit    = (cu[i] <= rem_s) || (rem_i == W_B);
    end else begin : g_tail
      assign cu[i]  = cu[i-1] + SU_W'(u);
      assign cd[i]  = cd[i-1] + SD_W'(d);
      assign prior  = go[i-1];
      assign fit    = (cu[i] <= rem_s);
    end

    assign elig   = prior & valid_i[i] & fit;
    assign rob_ok = (FREE_W'(cu[i]) <= rob_free_i);
    assign prf_ok = (FREE_W'(cd[i]) <= prf_free_i);
    assign sch_ok = (FREE_W'(i + 1) <= sched_free_i);

    assign go[i]      = elig & rob_ok & prf_ok & sch_ok;
    assign blk_rob[i] = elig & ~rob_ok;
    assign blk_prf[i] = elig & rob_ok & ~prf_ok;
    assign blk_sch[i] = elig & rob_ok & prf_ok & ~sch_ok;
  end

  // go is contiguous from lane 0, so the last set lane holds the totals
  always_comb begin
    rob_sum_o = '0;
    prf_sum_o = '0;
    sch_cnt_o = '0;
    for (int i = 0; i < LANES; i++) begin
      if (go[i]) begin
        rob_sum_o = cu[i];
        prf_sum_o = cd[i];
        sch_cnt_o = LC_W'(i + 1);
      end
    end
  end

  // at most one lane can be blocked per cycle
  always_comb begin
    if (|blk_rob)      cause_o = CAUSE_ROB;
    else if (|blk_prf) cause_o = CAUSE_PRF;
    else if (|blk_sch) cause_o = CAUSE_SCHED;
    else               cause_o = CAUSE_NONE;
  end

  assign go_o = go;
endmodule

// File: rtl/uop_disp_stall_ctr.sv
module uop_disp_stall_ctr #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  timeunit 1ns; timeprecision 100ps;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (inc_i && ~&cnt_q)      cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/uop_dispatch.sv
module uop_dispatch import uop_dispatch_pkg::*; #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned UOP_W  = 4,
  parameter int unsigned DST_W  = 2,
  parameter int unsigned FREE_W = 8,
  parameter int unsigned CNT_W  = 32,
  localparam int unsigned SU_W  = UOP_W + $clog2(LANES + 1),
  localparam int unsigned SD_W  = DST_W + $clog2(LANES + 1),
  localparam int unsigned LC_W  = $clog2(LANES + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [LANES-1:0]       in_valid_i,
  input  logic [LANES*UOP_W-1:0] in_uops_i,
  input  logic [LANES*DST_W-1:0] in_dsts_i,
  output logic [LANES-1:0]       in_ready_o,
  input  logic [FREE_W-1:0]      rob_free_i,
  input  logic [FREE_W-1:0]      prf_free_i,
  input  logic [FREE_W-1:0]      sched_free_i,
  output logic                   alloc_o,
  output logic [SU_W-1:0]        rob_alloc_o,
  output logic [SD_W-1:0]        prf_alloc_o,
  output logic [LC_W-1:0]        sched_alloc_o,
  output logic [CNT_W-1:0]       stall_rob_o,
  output logic [CNT_W-1:0]       stall_prf_o,
  output logic [CNT_W-1:0]       stall_sched_o
);
  timeunit 1ns; timeprecision 100ps;

  localparam int unsigned BUD_W = $clog2(WIDTH + 1);

  logic             busy;
  logic [BUD_W-1:0] rem;
  logic [LANES-1:0] go;
  stall_cause_e     cause;

  uop_disp_budget #(.WIDTH(WIDTH), .UOP_W(UOP_W)) i_budget (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (go[0]),
    .uops0_i (in_uops_i[UOP_W-1:0]),
    .busy_o  (busy),
    .rem_o   (rem)
  );

  uop_disp_lanes #(
    .LANES(LANES), .WIDTH(WIDTH), .UOP_W(UOP_W), .DST_W(DST_W), .FREE_W(FREE_W)
  ) i_lanes (
    .valid_i      (in_valid_i),
    .uops_i       (in_uops_i),
    .dsts_i       (in_dsts_i),
    .busy_i       (busy),
    .rem_i        (rem),
    .rob_free_i   (rob_free_i),
    .prf_free_i   (prf_free_i),
    .sched_free_i (sched_free_i),
    .go_o         (go),
    .rob_sum_o    (rob_alloc_o),
    .prf_sum_o    (prf_alloc_o),
    .sch_cnt_o    (sched_alloc_o),
    .cause_o      (cause)
  );

  logic [NUM_CAUSES-1:0] inc;
  logic [CNT_W-1:0]      cnt [NUM_CAUSES];

  assign inc = {cause == CAUSE_SCHED, cause == CAUSE_PRF, cause == CAUSE_ROB};

  for (genvar c = 0; c < NUM_CAUSES; c++) begin : g_ctr
    uop_disp_stall_ctr #(.CNT_W(CNT_W)) i_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (inc[c]),
      .cnt_o  (cnt[c])
    );
  end

  assign in_ready_o    = go;
  assign alloc_o       = |go;
  assign stall_rob_o   = cnt[0];
  assign stall_prf_o   = cnt[1];
  assign stall_sched_o = cnt[2];
endmodule

// File: rtl/uop_dispatch_chk.sv
module uop_dispatch_chk #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned UOP_W  = 4,
  parameter int unsigned DST_W  = 2,
  parameter int unsigned FREE_W = 8,
  parameter int unsigned CNT_W  = 32,
  localparam int unsigned SU_W  = UOP_W + $clog2(LANES + 1),
  localparam int unsigned SD_W  = DST_W + $clog2(LANES + 1),
  localparam int unsigned LC_W  = $clog2(LANES + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [LANES-1:0]  valid_i,
  input logic [LANES-1:0]  ready_i,
  input logic [UOP_W-1:0]  uops0_i,
  input logic [FREE_W-1:0] rob_free_i,
  input logic [FREE_W-1:0] prf_free_i,
  input logic [FREE_W-1:0] sched_free_i,
  input logic              alloc_i,
  input logic [SU_W-1:0]   rob_alloc_i,
  input logic [SD_W-1:0]   prf_alloc_i,
  input logic [LC_W-1:0]   sched_alloc_i,
  input logic [CNT_W-1:0]  cnt_rob_i,
  input logic [CNT_W-1:0]  cnt_prf_i,
  input logic [CNT_W-1:0]  cnt_sch_i
);
  timeunit 1ns; timeprecision 100ps;

  localparam logic [UOP_W-1:0] W_U = UOP_W'(WIDTH);
  localparam logic [SU_W-1:0]  W_S = SU_W'(WIDTH);

  p_ready_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i & ~valid_i) == '0);

  p_in_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ready_i + LANES'(1)) & ready_i) == '0);

  p_rob_room_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> (FREE_W'(rob_alloc_i) <= rob_free_i));

  p_prf_room_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> (FREE_W'(prf_alloc_i) <= prf_free_i));

  p_sched_room_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> (FREE_W'(sched_alloc_i) <= sched_free_i));

  p_budget_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(ready_i) > 1) |-> (rob_alloc_i <= W_S));

  p_carry_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i[0] && (uops0_i > W_U)) |=> (ready_i == '0));

  p_alloc_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alloc_i |-> (ready_i == '0 && rob_alloc_i == '0 && prf_alloc_i == '0 && sched_alloc_i == '0));

  p_one_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({cnt_rob_i != $past(cnt_rob_i), cnt_prf_i != $past(cnt_prf_i),
                cnt_sch_i != $past(cnt_sch_i)}) <= 1);

  p_no_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_rob_i >= $past(cnt_rob_i)) && (cnt_prf_i >= $past(cnt_prf_i)) &&
    (cnt_sch_i >= $past(cnt_sch_i)));
endmodule

bind uop_dispatch uop_dispatch_chk #(
  .LANES(LANES), .WIDTH(WIDTH), .UOP_W(UOP_W), .DST_W(DST_W), .FREE_W(FREE_W), .CNT_W(CNT_W)
) i_uop_dispatch_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .valid_i       (in_valid_i),
  .ready_i       (in_ready_o),
  .uops0_i       (in_uops_i[UOP_W-1:0]),
  .rob_free_i    (rob_free_i),
  .prf_free_i    (prf_free_i),
  .sched_free_i  (sched_free_i),
  .alloc_i       (alloc_o),
  .rob_alloc_i   (rob_alloc_o),
  .prf_alloc_i   (prf_alloc_o),
  .sched_alloc_i (sched_alloc_o),
  .cnt_rob_i     (stall_rob_o),
  .cnt_prf_i     (stall_prf_o),
  .cnt_sch_i     (stall_sched_o)
);

// File: tb/test_uop_dispatch.sv
module test_uop_dispatch;
  timeunit 1ns; timeprecision 100ps;

  localparam int unsigned LANES  = 2;
  localparam int unsigned WIDTH  = 4;
  localparam int unsigned UOP_W  = 4;
  localparam int unsigned DST_W  = 2;
  localparam int unsigned FREE_W = 8;
  localparam int unsigned CNT_W  = 4;
  localparam int unsigned SU_W   = UOP_W + $clog2(LANES + 1);
  localparam int unsigned SD_W   = DST_W + $clog2(LANES + 1);
  localparam int unsigned LC_W   = $clog2(LANES + 1);
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LANES-1:0]       in_valid = '0;
  logic [LANES*UOP_W-1:0] in_uops = '0;
  logic [LANES*DST_W-1:0] in_dsts = '0;
  logic [LANES-1:0]       in_ready;
  logic [FREE_W-1:0]      rob_free = '0, prf_free = '0, sched_free = '0;
  logic                   alloc;
  logic [SU_W-1:0]        rob_alloc;
  logic [SD_W-1:0]        prf_alloc;
  logic [LC_W-1:0]        sched_alloc;
  logic [CNT_W-1:0]       stall_rob, stall_prf, stall_sched;

  always #2.5 clk = ~clk;

  uop_dispatch #(
    .LANES(LANES), .WIDTH(WIDTH), .UOP_W(UOP_W), .DST_W(DST_W), .FREE_W(FREE_W), .CNT_W(CNT_W)
  ) i_uop_dispatch (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_uops_i(in_uops), .in_dsts_i(in_dsts), .in_ready_o(in_ready),
    .rob_free_i(rob_free), .prf_free_i(prf_free), .sched_free_i(sched_free),
    .alloc_o(alloc), .rob_alloc_o(rob_alloc), .prf_alloc_o(prf_alloc), .sched_alloc_o(sched_alloc),
    .stall_rob_o(stall_rob), .stall_prf_o(stall_prf), .stall_sched_o(stall_sched)
  );

  typedef struct {
    int    ready;
    int    alloc;
    int    rob;
    int    prf;
    int    sch;
    int    c_rob;
    int    c_prf;
    int    c_sch;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_err = 0;
  int m_carry = 0;
  int m_cnt[3] = '{0, 0, 0};

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // monitor: compares just after the driver's negedge update
  initial forever begin
    exp_t e;
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      e = q.pop_front();
      chk(e.tag, "ready", int'(in_ready), e.ready);
      chk(e.tag, "alloc", int'(alloc), e.alloc);
      chk(e.tag, "rob_alloc", int'(rob_alloc), e.rob);
      chk(e.tag, "prf_alloc", int'(prf_alloc), e.prf);
      chk(e.tag, "sched_alloc", int'(sched_alloc), e.sch);
      chk(e.tag, "stall_rob", int'(stall_rob), e.c_rob);
      chk(e.tag, "stall_prf", int'(stall_prf), e.c_prf);
      chk(e.tag, "stall_sched", int'(stall_sched), e.c_sch);
    end
  end

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic step(input logic [LANES-1:0] v, input int u0, input int d0, input int u1,
                      input int d1, input int rf, input int pf, input int sf, input string tag);
    exp_t e;
    int u[2];
    int d[2];
    int cu = 0, cd = 0, mask = 0, cause = 0;
    @(negedge clk);
    in_valid   = v;
    in_uops    = {UOP_W'(u1), UOP_W'(u0)};
    in_dsts    = {DST_W'(d1), DST_W'(d0)};
    rob_free   = FREE_W'(rf);
    prf_free   = FREE_W'(pf);
    sched_free = FREE_W'(sf);
    u[0] = u0; u[1] = u1; d[0] = d0; d[1] = d1;
    e.rob = 0; e.prf = 0; e.sch = 0;
    if (m_carry == 0) begin
      for (int i = 0; i < LANES; i++) begin
        if (!v[i]) break;
        cu += u[i];
        cd += d[i];
        if (i > 0 && cu > int'(WIDTH)) break;
        if (rf < cu) begin cause = 1; break; end
        if (pf < cd) begin cause = 2; break; end
        if (sf < i + 1) begin cause = 3; break; end
        mask |= (1 << i);
        e.rob = cu; e.prf = cd; e.sch = i + 1;
      end
    end
    e.ready = mask;
    e.alloc = (mask != 0) ? 1 : 0;
    e.c_rob = m_cnt[0]; e.c_prf = m_cnt[1]; e.c_sch = m_cnt[2];
    e.tag = tag;
    q.push_back(e);
    if (m_carry != 0) m_carry = (m_carry > int'(WIDTH)) ? m_carry - int'(WIDTH) : 0;
    else if ((mask & 1) != 0 && u0 > int'(WIDTH)) m_carry = u0 - int'(WIDTH);
    if (cause != 0 && m_cnt[cause-1] < CMAX) m_cnt[cause-1]++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = '0;
    rst_n = 1'b0;
    m_carry = 0;
    m_cnt = '{0, 0, 0};
    @(negedge clk);
    #1;
    chk("R9", "stall_rob_in_reset", int'(stall_rob), 0);
    chk("R9", "stall_prf_in_reset", int'(stall_prf), 0);
    chk("R9", "stall_sched_in_reset", int'(stall_sched), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    do_reset();
    // R9 full budget after reset, R6 sums over two lanes
    step(2'b11, 2, 1, 2, 1, 20, 20, 3, "R9_R6_two_lanes");
    // R2 second lane exceeds budget
    step(2'b11, 3, 1, 2, 1, 20, 20, 3, "R2_budget_cut");
    // R2 invalid lane 0 blocks lane 1
    step(2'b10, 1, 0, 1, 0, 20, 20, 3, "R2_gap");
    // R3 oversized head, R4 carry 6 then 2
    step(2'b01, 10, 2, 0, 0, 20, 20, 3, "R3_oversize");
    step(2'b11, 1, 1, 1, 1, 20, 20, 3, "R4_carry_a");
    step(2'b11, 1, 1, 1, 1, 20, 20, 3, "R4_carry_b");
    step(2'b11, 1, 1, 1, 1, 20, 20, 3, "R4_drained");
    // R3 exact width, no carry, lane 1 cut
    step(2'b11, 4, 0, 1, 0, 20, 20, 3, "R3_exact");
    step(2'b01, 5, 1, 0, 0, 20, 20, 3, "R4_carry_one");
    step(2'b01, 1, 1, 0, 0, 20, 20, 3, "R4_carry_one_hold");
    step(2'b01, 1, 1, 0, 0, 20, 20, 3, "R4_carry_one_done");
    // R1 / R7 per-cause stalls
    step(2'b01, 4, 0, 0, 0, 3, 20, 3, "R1_R7_rob");
    step(2'b01, 2, 2, 0, 0, 0, 0, 0, "R7_priority_rob");
    step(2'b01, 2, 2, 0, 0, 20, 1, 3, "R1_R7_prf");
    step(2'b01, 1, 0, 0, 0, 20, 20, 0, "R1_R7_sched");
    step(2'b11, 1, 1, 1, 1, 20, 20, 1, "R1_R7_lane1_sched");
    step(2'b11, 1, 1, 2, 2, 20, 2, 3, "R1_R7_lane1_prf");
    // R7 carry cycles count nothing
    step(2'b01, 9, 1, 0, 0, 20, 20, 3, "R7_carry_start");
    step(2'b11, 1, 1, 1, 1, 0, 0, 0, "R7_carry_short_a");
    step(2'b11, 1, 1, 1, 1, 0, 0, 0, "R7_carry_short_b");
    step(2'b11, 1, 1, 1, 1, 0, 0, 0, "R7_after_carry");
    // R9 reset mid-carry
    step(2'b01, 12, 0, 0, 0, 20, 20, 3, "R9_pre_reset");
    do_reset();
    step(2'b01, 1, 0, 0, 0, 20, 20, 3, "R9_carry_cleared");
    // R8 saturation
    for (int k = 0; k < CMAX + 5; k++) step(2'b01, 1, 0, 0, 0, 0, 20, 3, "R8_saturate");
    // mixed traffic
    for (int k = 0; k < 300; k++) begin
      step(LANES'($urandom_range(3, 0)), $urandom_range(9, 1), $urandom_range(3, 0),
           $urandom_range(9, 1), $urandom_range(3, 0), $urandom_range(14, 0),
           $urandom_range(6, 0), $urandom_range(2, 0), "R1_R2_R4_R7_mixed");
    end
    @(negedge clk);
    in_valid = '0;
    #2;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule